// File: doc/BRIEF.md
# Input Power Protection Sequencer

This block is the clocked control core for an input-power protection switch that also has a battery switchover path. It receives synchronous digital flags from comparators elsewhere. One flag says the input is above the upper trip level, one says it is below the lower trip level, and one says the input is present at all. It also receives a switchover bit from the host. From these it produces two active-high enables: one for the main input pass switch and one for the battery switch.

When an input is plugged in, the main switch turns on only after the input has stayed inside the valid window for a full debounce interval. An overvoltage drops the switch at once. A dip below the lower level while the switch is on is given a blanking interval to recover. If the dip outlasts that interval, the switch is latched off until the input goes away completely. This keeps a weak adapter from making the switch cycle on and off.

Both interval lengths are parameters given in clock cycles. A 3-bit state output lets the surrounding logic and the bench follow each transition.

Top module: `pwr_guard_seq`

## Requirements
- R1: From idle, a present input moves the state to debouncing (1) at the next edge. The state becomes on (2) after DEB_CYCLES consecutive edges in debouncing with both the overvoltage and undervoltage flags low. An undervoltage during debouncing restarts that count.
- R2: While the overvoltage flag is high, main_en is low in that same cycle, with no clock delay. From debouncing, on or blanking, the state moves to overvoltage-off (4) at the next edge.
- R3: Leaving overvoltage-off once the flag clears goes to debouncing with the count at zero. The main switch returns only after a full DEB_CYCLES debounce.
- R4: An undervoltage flag in the on state moves to blanking (3), and main_en stays high. If the flag clears before BLK_CYCLES consecutive blanking edges, the state returns to on.
- R5: If the undervoltage flag stays high for BLK_CYCLES consecutive edges in blanking, the state becomes latched-off (5) and main_en goes low. Overvoltage, undervoltage and switchover inputs then leave the state and main_en unchanged until input-present drops.
- R6: A high switchover bit forces main_en low in the on and blanking states. A low bit returns main_en to the protection logic.
- R7: batt_en equals the switchover bit in every state.
- R8: Reset, or input-present low at any edge, puts the state in idle (0) with main_en low and the latch-off cleared.
- R9: main_en is high only in the on or blanking states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_flag | input | 1 | Input above upper trip level |
| uv_flag | input | 1 | Input below lower trip level |
| present | input | 1 | Input above power-on detect level |
| swover | input | 1 | Host battery switchover bit |
| main_en | output | 1 | Main pass switch enable |
| batt_en | output | 1 | Battery switch enable |
| state_o | output | 3 | Current state code (0 idle, 1 debouncing, 2 on, 3 blanking, 4 overvoltage-off, 5 latched-off) |

## Verification
The bench builds the block with DEB_CYCLES = 4 and BLK_CYCLES = 3. With these values a whole plug-in, a restarted debounce, an expiring blanking interval and a recovery just before expiry each fit in a handful of table rows. That makes it possible to check the exact edge on which each interval ends. The default values of millions of cycles would allow none of that. The short lengths also let the latched-off state be entered, probed with every ignored input, and released within one table walk.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [2:0] {
    PG_IDLE    = 3'd0,
    PG_DEBOUNCE = 3'd1,
    PG_ON      = 3'd2,
    PG_BLANK   = 3'd3,
    PG_OVOFF   = 3'd4,
    PG_LATCHED = 3'd5
  } pg_state_e;
endpackage

// File: rtl/pg_interval.sv
module pg_interval #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  // Counts consecutive cycles with run high; any low cycle restarts it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  assert_count_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pwr_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ov_flag,
  input  logic      uv_flag,
  input  logic      present,
  input  logic      deb_done,
  input  logic      blk_done,
  output logic      deb_run,
  output logic      blk_run,
  output pg_state_e state
);
  pg_state_e nxt;

  always_comb begin
    nxt = state;
    if (!present) nxt = PG_IDLE;
    else begin
      unique case (state)
        PG_IDLE:     nxt = PG_DEBOUNCE;
        PG_DEBOUNCE: if (ov_flag) nxt = PG_OVOFF;
                     else if (deb_done) nxt = PG_ON;
        PG_ON:       if (ov_flag) nxt = PG_OVOFF;
                     else if (uv_flag) nxt = PG_BLANK;
        PG_BLANK:    if (ov_flag) nxt = PG_OVOFF;
                     else if (!uv_flag) nxt = PG_ON;
                     else if (blk_done) nxt = PG_LATCHED;
        PG_OVOFF:    if (!ov_flag) nxt = PG_DEBOUNCE;
        PG_LATCHED:  nxt = PG_LATCHED;
        default:     nxt = PG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PG_IDLE;
    else        state <= nxt;
  end

  assign deb_run = (state == PG_DEBOUNCE) && !ov_flag && !uv_flag && present;
  assign blk_run = (state == PG_BLANK) && uv_flag && !ov_flag && present;

  assert_idle_on_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> state == PG_IDLE);
  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_LATCHED) && present |=> state == PG_LATCHED);
  assert_on_via_debounce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_IDLE) |=> state inside {PG_IDLE, PG_DEBOUNCE});
  assert_ov_leaves_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag && present && (state inside {PG_DEBOUNCE, PG_ON, PG_BLANK}) |=> state == PG_OVOFF);
  assert_latch_needs_uv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PG_BLANK) && !uv_flag |=> state != PG_LATCHED);
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int DEB_CYCLES = 2_500_000,
  parameter int BLK_CYCLES = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       present,
  input  logic       swover,
  output logic       main_en,
  output logic       batt_en,
  output logic [2:0] state_o
);
  pg_state_e state;
  logic deb_run, blk_run, deb_done, blk_done;

  pg_interval #(.LEN(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .run(deb_run), .done(deb_done));

  pg_interval #(.LEN(BLK_CYCLES)) u_blk (
    .clk(clk), .rst_n(rst_n), .run(blk_run), .done(blk_done));

  pg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .present(present), .deb_done(deb_done), .blk_done(blk_done),
    .deb_run(deb_run), .blk_run(blk_run), .state(state));

  // Overvoltage gates the enable without waiting for the state register.
  assign main_en = ((state == PG_ON) || (state == PG_BLANK)) && !swover && !ov_flag;
  assign batt_en = swover;
  assign state_o = state;

  assert_ov_kills_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |-> !main_en);
  assert_swover_main_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swover |-> !main_en);
  assert_main_only_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    main_en |-> (state_o == 3'd2 || state_o == 3'd3));
endmodule

// File: tb/pwr_guard_seq_tb.sv
module pwr_guard_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ov_flag = 1'b0, uv_flag = 1'b0, present = 1'b0, swover = 1'b0;
  logic main_en, batt_en;
  logic [2:0] state_o;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_guard_seq #(.DEB_CYCLES(4), .BLK_CYCLES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .present(present), .swover(swover), .main_en(main_en),
    .batt_en(batt_en), .state_o(state_o));

  // {present, ov, uv, sw, expected state, expected main_en, expected batt_en}
  localparam int NV = 36;
  localparam logic [8:0] VEC [NV] = '{
    {4'b1010, 3'd1, 1'b0, 1'b0},  // R1 plug-in while low
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1010, 3'd1, 1'b0, 1'b0},  // R1 restart on undervoltage
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd2, 1'b1, 1'b0},  // R1 on after 4 clean edges
    {4'b1001, 3'd2, 1'b0, 1'b1},  // R6 R7 switchover
    {4'b1000, 3'd2, 1'b1, 1'b0},  // R6 release
    {4'b1101, 3'd4, 1'b0, 1'b1},  // R2 overvoltage, switchover ignored
    {4'b1100, 3'd4, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},  // R3 full debounce again
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd2, 1'b1, 1'b0},
    {4'b1010, 3'd3, 1'b1, 1'b0},  // R4 blanking, stays on
    {4'b1000, 3'd2, 1'b1, 1'b0},  // R4 glitch recovered
    {4'b1010, 3'd3, 1'b1, 1'b0},
    {4'b1010, 3'd3, 1'b1, 1'b0},
    {4'b1010, 3'd3, 1'b1, 1'b0},
    {4'b1010, 3'd5, 1'b0, 1'b0},  // R5 latched off
    {4'b1101, 3'd5, 1'b0, 1'b1},  // R5 inputs ignored, R7 battery follows
    {4'b1000, 3'd5, 1'b0, 1'b0},  // R5 still latched
    {4'b0000, 3'd0, 1'b0, 1'b0},  // R8 unplug clears latch
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1000, 3'd2, 1'b1, 1'b0},  // R9 re-enabled
    {4'b1011, 3'd3, 1'b0, 1'b1},  // R6 switchover in blanking
    {4'b0010, 3'd0, 1'b0, 1'b0},  // R8 unplug during blanking
    {4'b1000, 3'd1, 1'b0, 1'b0},
    {4'b1100, 3'd4, 1'b0, 1'b0},  // R2 overvoltage during debounce
    {4'b1000, 3'd1, 1'b0, 1'b0}   // R3
  };

  task automatic check(input string req, input logic [2:0] st, input logic m, input logic b);
    n_tests++;
    if (state_o !== st || main_en !== m || batt_en !== b) begin
      n_fail++;
      $display("FAIL %s: state/main/batt got %0d/%0b/%0b expected %0d/%0b/%0b",
               req, state_o, main_en, batt_en, st, m, b);
    end
  endtask

  initial begin : watchdog
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", 3'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {present, ov_flag, uv_flag, swover} = VEC[i][8:5];
      @(negedge clk);
      check($sformatf("R1-table step %0d", i + 1), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // Drive back to on, then check the same-cycle overvoltage cutoff (R2).
    {present, ov_flag, uv_flag, swover} = 4'b1000;
    repeat (4) @(negedge clk);
    check("R1 on again", 3'd2, 1'b1, 1'b0);
    ov_flag = 1'b1;
    #1;
    check("R2 immediate cutoff before edge", 3'd2, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 overvoltage-off", 3'd4, 1'b0, 1'b0);

    // Reset while on (R8).
    ov_flag = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 on after overvoltage", 3'd2, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule